// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Request Controller

This block turns a simple user request port into the command and data sequence of an external synchronous SRAM. That SRAM has one bidirectional data port, and the port moves two words in every clock, one on each clock edge. Each user request is a read or a write. It carries a pair address, a two-word write payload and one enable bit for each byte lane of each word. The controller puts at most one command per clock on the single-data-rate address and control bus. Every access is a fixed burst of two words.

Write data leaves through two edge lanes: the rising-edge word and the falling-edge word, which a DDR output cell merges onto the pads. A single output-enable bit controls the shared data pins. Read data comes back through two matching capture lanes a fixed number of cycles after the command. The controller joins the two words into one wide word and raises a one-cycle valid strobe. The controller holds off a write that would drive the bus while read data is still returning. It does this by dropping the user ready signal for that write, so the request waits and is not lost.

Top module: `sram_b2_ctrl`

## Requirements
- R1: While rst_ni is low: mem_ld_no is 1, mem_dq_oe_o is 0, every byte-write strobe is 1, rd_valid_o is 0 and req_ready_o is 1.
- R2: A request accepted at a rising edge (req_valid_i and req_ready_o both high) is on the memory bus for the whole next cycle. In that cycle mem_ld_no is 0, mem_addr_o equals the request address, and mem_rw_o is 1 for a read and 0 for a write.
- R3: In a cycle after which no request was accepted, mem_ld_no is 1 and mem_dq_oe_o is 0, whatever req_write_i and req_addr_i carry.
- R4: During a write command cycle, mem_dq_oe_o is 1. mem_dq_rise_o carries req_wdata_i[DW-1:0] (the first word), and mem_dq_fall_o carries req_wdata_i[2*DW-1:DW] (the second word). mem_dq_oe_o is 0 in every other cycle.
- R5: Byte lane k covers data bits [k*LW +: LW], with LW = DW/BW. Normally BW = DW/9; at DW = 8 there are two 4-bit nibble lanes. In a write command cycle, mem_bw_rise_no[k] = ~req_be_i[k] and mem_bw_fall_no[k] = ~req_be_i[BW+k]. In read and idle cycles, all strobes are 1.
- R6: For a read whose command cycle is c, the memory presents its words on mem_dq_rise_i and mem_dq_fall_i in cycle c+RD_LAT. rd_valid_o is then high only in cycle c+RD_LAT+1, with rd_data_o = {fall word, rise word}.
- R7: Reads may be accepted in consecutive cycles. They then occupy consecutive command cycles and return in issue order.
- R8: mem_dq_oe_o is never 1 in a cycle that lies within RD_LAT+1 cycles after a read command cycle. A write presented just after a read that was issued in cycle c goes on the bus in cycle c+RD_LAT+2.
- R9: A read request is always ready. A write request is ready only when no read is in flight. A write that is not ready stays pending with mem_ld_no at 1, and it issues once ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the rising edge is the memory's primary edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge if valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | AW | Address of the two-word pair |
| req_wdata_i | input | 2*DW | Write payload, first word in the low half |
| req_be_i | input | 2*BW | Byte-lane enables, first word in the low half |
| rd_valid_o | output | 1 | One-cycle strobe for returned read data |
| rd_data_o | output | 2*DW | Returned pair, first word in the low half |
| mem_ld_no | output | 1 | Load strobe to memory, active low |
| mem_rw_o | output | 1 | 1 read, 0 write |
| mem_addr_o | output | AW | Memory address |
| mem_bw_rise_no | output | BW | Byte-write strobes for the rising-edge word, active low |
| mem_bw_fall_no | output | BW | Byte-write strobes for the falling-edge word, active low |
| mem_dq_rise_o | output | DW | Write word for the rising edge |
| mem_dq_fall_o | output | DW | Write word for the falling edge |
| mem_dq_oe_o | output | 1 | Data pin output enable |
| mem_dq_rise_i | input | DW | Captured rising-edge read word |
| mem_dq_fall_i | input | DW | Captured falling-edge read word |

## Verification
If the read-tracking pipe lost or doubled an entry, rd_valid_o would appear or go missing exactly RD_LAT+1 cycles after the command. The user side would then see either a lost read or data taken from garbage input lanes. A wrong in-flight indication shows within one cycle, as a write that either drives mem_dq_oe_o into returning read data or stalls longer than RD_LAT+1 cycles. A wrong lane or edge mapping corrupts the stored data only in specific lanes. This shows at the next read of that address, so every written address is read back.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;

  typedef enum logic {
    RW_WRITE = 1'b0,
    RW_READ  = 1'b1
  } rw_e;

  // byte-write lanes per word: nibbles at 8 bits, 9-bit lanes otherwise
  function automatic int unsigned lane_count(input int unsigned dw);
    return (dw == 8) ? 2 : (dw + 8) / 9;
  endfunction

endpackage

// File: rtl/sram_b2_issue.sv
module sram_b2_issue
  import sram_b2_pkg::*;
#(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 18,
  parameter int unsigned BW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [2*DW-1:0] wdata_i,
  input  logic [2*BW-1:0] be_i,
  output logic            ld_no,
  output logic            rw_o,
  output logic [AW-1:0]   addr_o,
  output logic [BW-1:0]   bw_rise_no,
  output logic [BW-1:0]   bw_fall_no,
  output logic [DW-1:0]   dq_rise_o,
  output logic [DW-1:0]   dq_fall_o,
  output logic            oe_o
);

  logic          wr_fire;
  logic [BW-1:0] bw_rise_d, bw_fall_d;

  assign wr_fire = fire_i & wr_i;

  for (genvar k = 0; k < BW; k++) begin : g_lane
    assign bw_rise_d[k] = ~(wr_fire & be_i[k]);
    assign bw_fall_d[k] = ~(wr_fire & be_i[BW+k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_no      <= 1'b1;
      rw_o       <= RW_READ;
      addr_o     <= '0;
      bw_rise_no <= '1;
      bw_fall_no <= '1;
      dq_rise_o  <= '0;
      dq_fall_o  <= '0;
      oe_o       <= 1'b0;
    end else begin
      ld_no      <= ~fire_i;
      oe_o       <= wr_fire;
      bw_rise_no <= bw_rise_d;
      bw_fall_no <= bw_fall_d;
      if (fire_i) begin
        rw_o   <= wr_i ? RW_WRITE : RW_READ;
        addr_o <= addr_i;
      end
      if (wr_fire) begin
        dq_rise_o <= wdata_i[DW-1:0];
        dq_fall_o <= wdata_i[2*DW-1:DW];
      end
    end
  end

endmodule

// File: rtl/sram_b2_rd_track.sv
module sram_b2_rd_track #(
  parameter int unsigned DW     = 36,
  parameter int unsigned RD_LAT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_fire_i,
  input  logic [DW-1:0]   dq_rise_i,
  input  logic [DW-1:0]   dq_fall_i,
  output logic            busy_o,
  output logic            valid_o,
  output logic [2*DW-1:0] data_o
);

  localparam int unsigned PW = RD_LAT + 1;

  // bit j high: read command was on the bus j cycles ago
  logic [PW-1:0] pipe_q;

  assign busy_o = |pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q  <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      pipe_q  <= {pipe_q[PW-2:0], rd_fire_i};
      valid_o <= pipe_q[PW-1];
      if (pipe_q[PW-1]) data_o <= {dq_fall_i, dq_rise_i};
    end
  end

endmodule

// File: rtl/sram_b2_ctrl.sv
module sram_b2_ctrl
  import sram_b2_pkg::*;
#(
  parameter int unsigned DW     = 36,
  parameter int unsigned AW     = 18,
  parameter int unsigned RD_LAT = 2,
  localparam int unsigned BW    = lane_count(DW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [2*DW-1:0] req_wdata_i,
  input  logic [2*BW-1:0] req_be_i,
  output logic            rd_valid_o,
  output logic [2*DW-1:0] rd_data_o,
  output logic            mem_ld_no,
  output logic            mem_rw_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [BW-1:0]   mem_bw_rise_no,
  output logic [BW-1:0]   mem_bw_fall_no,
  output logic [DW-1:0]   mem_dq_rise_o,
  output logic [DW-1:0]   mem_dq_fall_o,
  output logic            mem_dq_oe_o,
  input  logic [DW-1:0]   mem_dq_rise_i,
  input  logic [DW-1:0]   mem_dq_fall_i
);

  logic rd_busy;
  logic fire;

  // writes wait until no read data is due, leaving one idle bus cycle
  assign req_ready_o = ~(req_write_i & rd_busy);
  assign fire        = req_valid_i & req_ready_o;

  sram_b2_issue #(.DW(DW), .AW(AW), .BW(BW)) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .wr_i       (req_write_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .be_i       (req_be_i),
    .ld_no      (mem_ld_no),
    .rw_o       (mem_rw_o),
    .addr_o     (mem_addr_o),
    .bw_rise_no (mem_bw_rise_no),
    .bw_fall_no (mem_bw_fall_no),
    .dq_rise_o  (mem_dq_rise_o),
    .dq_fall_o  (mem_dq_fall_o),
    .oe_o       (mem_dq_oe_o)
  );

  sram_b2_rd_track #(.DW(DW), .RD_LAT(RD_LAT)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_fire_i (fire & ~req_write_i),
    .dq_rise_i (mem_dq_rise_i),
    .dq_fall_i (mem_dq_fall_i),
    .busy_o    (rd_busy),
    .valid_o   (rd_valid_o),
    .data_o    (rd_data_o)
  );

endmodule

// File: rtl/sram_b2_ctrl_chk.sv
module sram_b2_ctrl_chk #(
  parameter int unsigned BW     = 4,
  parameter int unsigned RD_LAT = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic          req_ready_o,
  input logic          mem_ld_no,
  input logic          mem_rw_o,
  input logic [BW-1:0] mem_bw_rise_no,
  input logic [BW-1:0] mem_bw_fall_no,
  input logic          mem_dq_oe_o,
  input logic          rd_valid_o
);

  // reads seen on the bus, bit j = read command j+1 cycles ago
  logic [RD_LAT:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= {seen_q[RD_LAT-1:0], ~mem_ld_no & mem_rw_o};
  end

  AST_ISSUE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !mem_ld_no); // R2

  AST_IDLE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> (mem_ld_no && !mem_dq_oe_o)); // R3

  AST_OE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_ld_no && !mem_rw_o)); // R4

  AST_BW_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ld_no || mem_rw_o) |-> ((&mem_bw_rise_no) && (&mem_bw_fall_no))); // R5

  AST_RD_VALID_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o == seen_q[RD_LAT]); // R6

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (seen_q == '0)); // R8

  AST_READ_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |-> req_ready_o); // R9

endmodule

bind sram_b2_ctrl sram_b2_ctrl_chk #(.BW(BW), .RD_LAT(RD_LAT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_write_i    (req_write_i),
  .req_ready_o    (req_ready_o),
  .mem_ld_no      (mem_ld_no),
  .mem_rw_o       (mem_rw_o),
  .mem_bw_rise_no (mem_bw_rise_no),
  .mem_bw_fall_no (mem_bw_fall_no),
  .mem_dq_oe_o    (mem_dq_oe_o),
  .rd_valid_o     (rd_valid_o)
);

// File: tb/tb_sram_b2_ctrl.sv
`timescale 1ns/1ps
module tb_sram_b2_ctrl;
  localparam int DW = 36, AW = 18, RD_LAT = 2, BW = 4, LW = 9;

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [15:0] seed;
    logic [7:0]  be;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'h1, 16'hA1B2, 8'hFF},
    '{1'b1, 4'h2, 16'h3C4D, 8'h0F},
    '{1'b1, 4'h3, 16'h5E6F, 8'hA5},
    '{1'b0, 4'h1, 16'h0000, 8'h00},
    '{1'b0, 4'h2, 16'h0000, 8'h00},
    '{1'b0, 4'h3, 16'h0000, 8'h00},
    '{1'b1, 4'h4, 16'h7788, 8'hFF},
    '{1'b0, 4'h4, 16'h0000, 8'h00},
    '{1'b0, 4'h5, 16'h0000, 8'h00},
    '{1'b1, 4'h1, 16'h9911, 8'hF0},
    '{1'b0, 4'h1, 16'h0000, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic            req_valid, req_ready, req_write;
  logic [AW-1:0]   req_addr;
  logic [2*DW-1:0] req_wdata;
  logic [2*BW-1:0] req_be;
  logic            rd_valid;
  logic [2*DW-1:0] rd_data;
  logic            mem_ld_n, mem_rw, mem_oe;
  logic [AW-1:0]   mem_addr;
  logic [BW-1:0]   bw_rise_n, bw_fall_n;
  logic [DW-1:0]   dq_rise_o, dq_fall_o;
  logic [DW-1:0]   dq_rise_i = '1, dq_fall_i = '1;

  sram_b2_ctrl #(.DW(DW), .AW(AW), .RD_LAT(RD_LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .mem_ld_no(mem_ld_n), .mem_rw_o(mem_rw), .mem_addr_o(mem_addr),
    .mem_bw_rise_no(bw_rise_n), .mem_bw_fall_no(bw_fall_n),
    .mem_dq_rise_o(dq_rise_o), .mem_dq_fall_o(dq_fall_o), .mem_dq_oe_o(mem_oe),
    .mem_dq_rise_i(dq_rise_i), .mem_dq_fall_i(dq_fall_i)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [2*DW-1:0] gold [16];
  logic [2*DW-1:0] model [16];
  logic            ret_vld [8];
  logic [2*DW-1:0] ret_data [8];
  logic [2*DW-1:0] exp_q [$];
  int              exp_cyc_q [$];
  int              last_rd = -100;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and return-path monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ret_vld[cyc % 8]) begin
        dq_rise_i = ret_data[cyc % 8][DW-1:0];
        dq_fall_i = ret_data[cyc % 8][2*DW-1:DW];
        ret_vld[cyc % 8] = 1'b0;
      end else begin
        dq_rise_i = '1;
        dq_fall_i = '1;
      end
      if (!mem_ld_n && mem_rw) begin
        ret_vld[(cyc + RD_LAT) % 8]  = 1'b1;
        ret_data[(cyc + RD_LAT) % 8] = model[mem_addr[3:0]];
        last_rd = cyc;
      end
      if (!mem_ld_n && !mem_rw) begin
        for (int k = 0; k < BW; k++) begin
          if (!bw_rise_n[k]) model[mem_addr[3:0]][k*LW +: LW] = dq_rise_o[k*LW +: LW];
          if (!bw_fall_n[k]) model[mem_addr[3:0]][DW + k*LW +: LW] = dq_fall_o[k*LW +: LW];
        end
      end
      if (mem_oe)
        chk(cyc - last_rd > RD_LAT + 1, "R8", "oe too close to read", cyc - last_rd, RD_LAT + 2);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R6", "unexpected rd_valid", 1, 0);
        else begin
          chk(rd_data == exp_q[0], "R6", "read data", rd_data, exp_q[0]);
          chk(cyc == exp_cyc_q[0], "R7", "read return cycle", cyc, exp_cyc_q[0]);
          void'(exp_q.pop_front());
          void'(exp_cyc_q.pop_front());
        end
      end
    end
  end

  // called at a negedge; returns at the negedge of the command cycle
  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [2*DW-1:0] d,
                       input logic [2*BW-1:0] be, output int bus_cyc, output int stalls);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    stalls = 0;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      chk(mem_ld_n == 1'b1, "R9", "held write must not issue", mem_ld_n, 1);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    bus_cyc = cyc;
    chk(mem_ld_n == 1'b0, "R2", "ld strobe", mem_ld_n, 0);
    chk(mem_addr == a, "R2", "address", mem_addr, a);
    chk(mem_rw == ~wr, "R2", "rw select", mem_rw, ~wr);
    chk(mem_oe == wr, "R4", "output enable", mem_oe, wr);
    if (wr) begin
      chk(dq_rise_o == d[DW-1:0], "R4", "rise word", dq_rise_o, d[DW-1:0]);
      chk(dq_fall_o == d[2*DW-1:DW], "R4", "fall word", dq_fall_o, d[2*DW-1:DW]);
      chk(bw_rise_n == ~be[BW-1:0], "R5", "rise strobes", bw_rise_n, ~be[BW-1:0]);
      chk(bw_fall_n == ~be[2*BW-1:BW], "R5", "fall strobes", bw_fall_n, ~be[2*BW-1:BW]);
      for (int k = 0; k < BW; k++) begin
        if (be[k])    gold[a[3:0]][k*LW +: LW]      = d[k*LW +: LW];
        if (be[BW+k]) gold[a[3:0]][DW + k*LW +: LW] = d[DW + k*LW +: LW];
      end
    end else begin
      chk(&{bw_rise_n, bw_fall_n}, "R5", "strobes idle on read", {bw_rise_n, bw_fall_n}, 8'hFF);
      exp_q.push_back(gold[a[3:0]]);
      exp_cyc_q.push_back(cyc + RD_LAT + 1);
    end
  endtask

  initial begin
    int bc, st, rc, wc;
    for (int i = 0; i < 16; i++) begin gold[i] = '0; model[i] = '0; end
    for (int i = 0; i < 8; i++) begin ret_vld[i] = 1'b0; ret_data[i] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    chk(mem_ld_n == 1'b1, "R1", "reset ld", mem_ld_n, 1);
    chk(mem_oe == 1'b0, "R1", "reset oe", mem_oe, 0);
    chk(&{bw_rise_n, bw_fall_n}, "R1", "reset strobes", {bw_rise_n, bw_fall_n}, 8'hFF);
    chk(rd_valid == 1'b0, "R1", "reset rd_valid", rd_valid, 0);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      issue(VEC[i].wr, AW'(VEC[i].addr), {VEC[i].seed[7:0], {4{VEC[i].seed}}}, VEC[i].be, bc, st);
    repeat (8) @(negedge clk);

    // R3: no valid, other inputs toggling
    for (int i = 0; i < 4; i++) begin
      req_write = i[0]; req_addr = AW'(i * 5 + 3);
      @(negedge clk);
      chk(mem_ld_n == 1'b1 && mem_oe == 1'b0, "R3", "idle bus", {mem_ld_n, mem_oe}, 2'b10);
    end

    // R8/R9: write right after a read
    issue(1'b0, AW'(2), '0, '0, rc, st);
    issue(1'b1, AW'(6), {8'h42, {4{16'hC0DE}}}, 8'hFF, wc, st);
    chk(st == RD_LAT + 1, "R9", "write stall cycles", st, RD_LAT + 1);
    chk(wc == rc + RD_LAT + 2, "R8", "write after read cycle", wc, rc + RD_LAT + 2);

    // R9: read right after a write issues next cycle
    issue(1'b1, AW'(7), {8'h13, {4{16'h5A5A}}}, 8'h3C, wc, st);
    issue(1'b0, AW'(7), '0, '0, rc, st);
    chk(rc == wc + 1 && st == 0, "R9", "read after write", rc, wc + 1);

    // R7: back-to-back reads
    issue(1'b0, AW'(6), '0, '0, rc, st);
    for (int i = 1; i < 4; i++) begin
      issue(1'b0, AW'(i), '0, '0, bc, st);
      chk(bc == rc + i, "R7", "consecutive read slots", bc, rc + i);
    end
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "all reads returned", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule